// File: doc/BRIEF.md
# Tone Duration Steering Validator

This block sits behind the frequency detector of a dual-tone keypad receiver. The detector raises `early_st` whenever it currently sees a valid tone pair, and it presents the matching 4-bit key code on `tone_code`. The detector's output chatters: speech can imitate a tone for a moment, and line noise can punch short holes into a real tone. The validator turns this raw indication into clean key events, using clocked counters in place of an analogue timing network. A pair is accepted only after it has persisted for a programmable number of millisecond ticks. A gap is accepted as a pause between keys only after it has persisted for a second programmable number of ticks. Anything shorter is absorbed.

On acceptance, the code is captured into `rx_code` and `guard_out` rises. After a short settling delay, `dly_steer` rises and `rx_new` pulses for one clock so that a register interface can set its "receive full" status. Once a pause has been validated, `dly_steer` clears, but the captured code stays until the next accepted pair. A common setting is a tone guard and a pause guard of about 40 ms each. With such a setting, bursts under about 20 ms are rejected and dropouts under about 20 ms are ridden through.

Top module: `steer_validator`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_code`, `dly_steer`, `guard_out` and `rx_new` are all 0 until a pair is accepted.
- R2: A pair is accepted at the clock edge of the N-th `ms_tick` counted while `early_st` stays continuously high, where N is `on_guard_ms`. A tick in the first cycle in which `early_st` is seen high is not counted. At that edge `rx_code` takes the value of `tone_code`.
- R3: If `early_st` falls before N ticks have been counted, nothing is registered: `rx_code` and `dly_steer` keep their values and `rx_new` stays 0.
- R4: After an acceptance, a low stretch of `early_st` that ends before M ticks are counted (M is `off_guard_ms`) leaves `rx_code` unchanged, keeps `dly_steer` high and produces no `rx_new`. When `early_st` returns, the tone counts as still present without a new guard wait.
- R5: A low stretch reaching M counted ticks is a valid pause. `dly_steer` clears at the edge of the M-th tick, and `rx_code` keeps the last accepted code.
- R6: `guard_out` is 1 in exactly the cycles after an acceptance in which the tone is held as present. It drops during a dropout and rises again when the tone returns.
- R7: `dly_steer` rises exactly SETTLE_CYC clocks after `rx_code` is updated. In that same cycle `rx_new` is 1 for one clock only. There is one such pulse per acceptance.
- R8: `tone_code` is sampled only at the accepting edge. Values shown before it during qualification, or after it while the tone lasts, do not reach `rx_code`.
- R9: A limit value of 0 on either guard input behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| early_st | input | 1 | Tone pair currently detected |
| tone_code | input | CODE_W | Key code from the detector |
| on_guard_ms | input | LIM_W | Ticks of presence needed to accept a pair |
| off_guard_ms | input | LIM_W | Ticks of absence needed to accept a pause |
| guard_out | output | 1 | Accepted tone currently present |
| rx_code | output | CODE_W | Last accepted key code |
| dly_steer | output | 1 | Delayed steering flag |
| rx_new | output | 1 | One-clock pulse per newly accepted code |

## Verification
The checker relies on `ms_tick` pulses being spaced more than SETTLE_CYC clocks apart. Under that condition a pause can never be validated while a settling delay is still pending, so every acceptance yields exactly one rising edge of `dly_steer` together with one `rx_new` pulse. It also relies on `early_st`, `tone_code` and the limits being synchronous to `clk`. The stimulus meets both conditions: it issues a tick every five clocks with a four-clock settling delay, and it changes every input only on the falling edge.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_QUAL_ON  = 2'd1,
        PH_LOCKED   = 2'd2,
        PH_QUAL_OFF = 2'd3
    } steer_ph_e;

endpackage

// File: rtl/steer_guard_cnt.sv
module steer_guard_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   nxt;
    logic [CNT_W-1:0] eff_limit;

    assign nxt       = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign eff_limit = (limit == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : limit;
    assign hit       = run && tick && (nxt >= {1'b0, eff_limit});

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && tick && !nxt[CNT_W]) begin
            cnt_d = nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/steer_settle.sv
module steer_settle #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic fire
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] cnt;
    } settle_t;

    settle_t s_q, s_d;

    assign fire = s_q.busy && (s_q.cnt == SW'(SETTLE_CYC - 1));

    always_comb begin
        s_d = s_q;
        if (cancel) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (fire) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/steer_validator.sv
module steer_validator
    import steer_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int LIM_W      = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              early_st,
    input  logic [CODE_W-1:0] tone_code,
    input  logic [LIM_W-1:0]  on_guard_ms,
    input  logic [LIM_W-1:0]  off_guard_ms,
    output logic              guard_out,
    output logic [CODE_W-1:0] rx_code,
    output logic              dly_steer,
    output logic              rx_new
);
    typedef struct packed {
        steer_ph_e         ph;
        logic [CODE_W-1:0] code;
        logic              dstd;
        logic              full;
        logic              gt;
    } vstate_t;

    vstate_t r_q, r_d;

    logic             cnt_clr, cnt_run, cnt_hit;
    logic [LIM_W-1:0] cnt_lim;
    logic             settle_start, settle_cancel, settle_fire;

    // guard counter control depends on registered phase only
    assign cnt_clr = (r_q.ph == PH_IDLE) || (r_q.ph == PH_LOCKED);
    assign cnt_run = ((r_q.ph == PH_QUAL_ON)  &&  early_st) ||
                     ((r_q.ph == PH_QUAL_OFF) && !early_st);
    assign cnt_lim = (r_q.ph == PH_QUAL_ON) ? on_guard_ms : off_guard_ms;

    steer_guard_cnt #(.CNT_W(LIM_W)) guard_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .tick  (ms_tick),
        .limit (cnt_lim),
        .hit   (cnt_hit)
    );

    steer_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (settle_start),
        .cancel (settle_cancel),
        .fire   (settle_fire)
    );

    always_comb begin
        r_d           = r_q;
        r_d.full      = 1'b0;
        settle_start  = 1'b0;
        settle_cancel = 1'b0;

        if (settle_fire) begin
            r_d.dstd = 1'b1;
            r_d.full = 1'b1;
        end

        unique case (r_q.ph)
            PH_IDLE: begin
                if (early_st) r_d.ph = PH_QUAL_ON;
            end
            PH_QUAL_ON: begin
                if (!early_st) begin
                    r_d.ph = PH_IDLE;
                end else if (cnt_hit) begin
                    r_d.ph       = PH_LOCKED;
                    r_d.code     = tone_code;
                    settle_start = 1'b1;
                end
            end
            PH_LOCKED: begin
                if (!early_st) r_d.ph = PH_QUAL_OFF;
            end
            PH_QUAL_OFF: begin
                if (early_st) begin
                    r_d.ph = PH_LOCKED;
                end else if (cnt_hit) begin
                    r_d.ph        = PH_IDLE;
                    r_d.dstd      = 1'b0;
                    r_d.full      = 1'b0;
                    settle_cancel = 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase

        r_d.gt = (r_d.ph == PH_LOCKED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ph <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign guard_out = r_q.gt;
    assign rx_code   = r_q.code;
    assign dly_steer = r_q.dstd;
    assign rx_new    = r_q.full;
endmodule

// File: rtl/steer_validator_chk.sv
module steer_validator_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              early_st,
    input logic              guard_out,
    input logic [CODE_W-1:0] rx_code,
    input logic              dly_steer,
    input logic              rx_new
);
    // R6: guard output only follows a cycle with the tone present
    p_gt_needs_tone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        guard_out |-> $past(early_st));

    // R3 / R8: the code moves only on an acceptance edge
    p_code_only_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_code) |-> $rose(guard_out));

    // R7: pulse coincides with the rising flag
    p_pulse_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_new |-> $rose(dly_steer));

    p_rise_has_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dly_steer) |-> rx_new);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_new |=> !rx_new);

    // R5: flag clears only in a pause and keeps the code
    p_clear_in_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dly_steer) |-> (!guard_out && !early_st && $stable(rx_code)));
endmodule

bind steer_validator steer_validator_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .early_st  (early_st),
    .guard_out (guard_out),
    .rx_code   (rx_code),
    .dly_steer (dly_steer),
    .rx_new    (rx_new)
);

// File: tb/steer_validator_tb_top.sv
module steer_validator_tb_top;
    localparam int TD  = 5;
    localparam int SET = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       early_st = 1'b0;
    logic [3:0] tone_code = 4'h0;
    logic [7:0] on_guard_ms = 8'd6;
    logic [7:0] off_guard_ms = 8'd4;
    logic       guard_out, dly_steer, rx_new;
    logic [3:0] rx_code;

    int n_chk = 0, n_fail = 0, n_pulse = 0, div = 0, cyc = 0;
    bit done = 1'b0;

    // reference model state
    int         m_ph = 0, m_cnt = 0, m_left = 0;
    logic [3:0] m_code = 4'h0;
    logic       m_dstd = 1'b0, m_full = 1'b0, m_gt = 1'b0;

    always #10 clk = ~clk;

    steer_validator #(.CODE_W(4), .LIM_W(8), .SETTLE_CYC(SET)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .early_st(early_st),
        .tone_code(tone_code), .on_guard_ms(on_guard_ms), .off_guard_ms(off_guard_ms),
        .guard_out(guard_out), .rx_code(rx_code), .dly_steer(dly_steer), .rx_new(rx_new)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // tick source
    always @(negedge clk) begin
        if (div == TD - 1) begin div <= 0; ms_tick <= 1'b1; end
        else begin div <= div + 1; ms_tick <= 1'b0; end
    end

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_left = 0; m_code = 4'h0;
            m_dstd = 1'b0; m_full = 1'b0; m_gt = 1'b0;
        end else begin
            int need_on, need_off;
            need_on  = (on_guard_ms == 0) ? 1 : int'(on_guard_ms);
            need_off = (off_guard_ms == 0) ? 1 : int'(off_guard_ms);
            m_full = 1'b0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin m_dstd = 1'b1; m_full = 1'b1; end
            end
            if (m_ph == 0) begin
                if (early_st) begin m_ph = 1; m_cnt = 0; end
            end else if (m_ph == 1) begin
                if (!early_st) m_ph = 0;
                else if (ms_tick) begin
                    m_cnt++;
                    if (m_cnt >= need_on) begin m_ph = 2; m_code = tone_code; m_left = SET; end
                end
            end else if (m_ph == 2) begin
                if (!early_st) begin m_ph = 3; m_cnt = 0; end
            end else begin
                if (early_st) m_ph = 2;
                else if (ms_tick) begin
                    m_cnt++;
                    if (m_cnt >= need_off) begin
                        m_ph = 0; m_dstd = 1'b0; m_full = 1'b0; m_left = 0;
                    end
                end
            end
            m_gt = (m_ph == 2);
        end
    end

    // compare every clock away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R8", "rx_code", rx_code, m_code);
            chk("R6", "guard_out", guard_out, m_gt);
            chk("R7", "dly_steer", dly_steer, m_dstd);
            chk("R7", "rx_new", rx_new, m_full);
            if (rx_new) n_pulse++;
        end
    end

    task automatic hold_ticks(int n);
        int seen = 0;
        while (seen < n) begin
            @(posedge clk);
            if (ms_tick) seen++;
        end
        @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "rx_code in reset", rx_code, 0);
        chk("R1", "dly_steer in reset", dly_steer, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "guard_out after reset", guard_out, 0);
        chk("R1", "rx_new after reset", rx_new, 0);

        // R3: short burst rejected
        tone_code = 4'h5; early_st = 1'b1;
        hold_ticks(3);
        early_st = 1'b0;
        hold_ticks(2);
        chk("R3", "code after short burst", rx_code, 0);
        chk("R3", "flag after short burst", dly_steer, 0);
        chk("R3", "pulses after short burst", n_pulse, 0);

        // R2 and R8: code changes during qualification, value at accept wins
        tone_code = 4'h3; early_st = 1'b1;
        hold_ticks(2);
        tone_code = 4'h7;
        hold_ticks(7);
        chk("R2", "accepted code", rx_code, 7);
        chk("R6", "guard high while tone held", guard_out, 1);
        chk("R7", "flag after settle", dly_steer, 1);
        chk("R7", "one pulse for first accept", n_pulse, 1);
        tone_code = 4'hE;
        hold_ticks(2);
        chk("R8", "late code ignored", rx_code, 7);

        // R4: dropout ridden through
        early_st = 1'b0;
        hold_ticks(2);
        chk("R6", "guard low in dropout", guard_out, 0);
        chk("R4", "flag held in dropout", dly_steer, 1);
        early_st = 1'b1;
        hold_ticks(1);
        chk("R4", "code after dropout", rx_code, 7);
        chk("R4", "no pulse from dropout", n_pulse, 1);
        chk("R6", "guard back after dropout", guard_out, 1);

        // R5: valid pause
        early_st = 1'b0;
        hold_ticks(6);
        chk("R5", "flag cleared by pause", dly_steer, 0);
        chk("R5", "code kept after pause", rx_code, 7);

        // R9: zero limit acts as one
        on_guard_ms = 8'd0;
        tone_code = 4'hB; early_st = 1'b1;
        hold_ticks(2);
        chk("R9", "accept with zero limit", rx_code, 'hB);
        off_guard_ms = 8'd0;
        early_st = 1'b0;
        hold_ticks(2);
        chk("R9", "pause with zero limit", dly_steer, 0);
        chk("R7", "total pulses", n_pulse, 2);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule